// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire management interface of an Ethernet PHY. Software launches a whole transaction with one write of a packed 32-bit command word. The word carries the start code, the opcode, the turnaround code, the 5-bit PHY address, the 5-bit register address and, for a write, 16 data bits.

After the write, the block sends a preamble of 32 ones and then the command word on MDIO, most significant bit first. The management clock MDC runs at a rate derived from a speed field. On a read, the block releases MDIO at the turnaround. It then shifts the 16 bits returned by the PHY into the low half of the data register. When the frame ends, a completion event bit is set. Software clears that bit by writing a one to it.

Top module: `mdio_master`

## Requirements
- R1: MDC idles low. While a frame runs, each MDC half period lasts N system clocks, where N is the value of `speed_cfg[DIV_W:1]` latched when the command is accepted. `speed_cfg[0]` is ignored, and N = 0 behaves as N = 1.
- R2: A frame consists of 64 bits, and MDIO is sampled on each MDC rising edge. Bits 0..31 are all ones. Bit 32+j carries command bit 31-j, with the start code in bits 31:30, the opcode in 29:28, the PHY address in 27:23, the register address in 22:18, the turnaround in 17:16 and the data in 15:0.
- R3: `mdio_o` changes only in the clock where MDC falls, or in the clock where a command is accepted.
- R4: Any opcode other than read (`10`) is sent as a write. The frame is driven (`mdio_oe` = 1) for all 64 bits, and the turnaround is always sent as `10`, whatever command bits 17:16 hold.
- R5: On a read (command bits 29:28 = `10`), `mdio_oe` is 0 from frame bit 46 onward. The values of `mdio_i` at the rising edges of bits 48..63 end up in `data_q[15:0]`, MSB first, and `data_q[31:16]` keeps the command.
- R6: `busy` rises in the clock after `cmd_we` is accepted and stays high for exactly 128*N clocks.
- R7: At the end of each frame, `evt_done` is set. A write with `evt_we` and `evt_wdata[23]` = 1 clears it. A write with bit 23 at 0 leaves it unchanged, whatever the other bits hold. If a set and a clear fall in the same clock, the set wins.
- R8: A `cmd_we` while `busy` is high is ignored. The frame in progress and `data_q` are unaffected.
- R9: After reset, `mdc`, `mdio_oe`, `busy` and `evt_done` are 0, and `data_q` is 0.
- R10: After a write frame, `data_q` holds the command word exactly as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_cfg | input | DIV_W+1 | Speed field; bits above bit 0 give the MDC half period |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Packed command word |
| evt_we | input | 1 | Event register write strobe |
| evt_wdata | input | 32 | Write-one-to-clear data; bit 23 is the completion event |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| data_q | output | 32 | Data register: the command word, with read data in the low half |
| busy | output | 1 | Frame in progress |
| evt_done | output | 1 | Completion event bit |

## Verification
The bench aims at three boundaries.

- **Speed field boundaries.** It uses a speed field of zero and of odd values. A divider that used bit 0, or that stalled on zero, would produce wrong half periods or a frame that never ends.
- **Turnaround.** On writes it sends random turnaround bits, which a design that copied them would put on the wire. On reads it places the last driven bit just before the release, where an off-by-one would fight the PHY or capture data shifted by a bit.
- **Mid-frame commands and the clear write.** It issues a command in the middle of a frame, which a design without the busy guard would use to corrupt the frame or the register. It also writes clears with bit 23 low, which a design that decoded the whole word would treat as clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam logic [5:0] TA_K   = 6'd46;
  localparam logic [5:0] DATA_K = 6'd48;
  localparam logic [5:0] LAST_K = 6'(FRAME_BITS - 1);

  typedef logic [1:0] op_t;
  localparam op_t OP_RD = 2'b10;

  // Half period in clocks; a zero field is treated as one.
  function automatic logic [15:0] eff_half(input logic [15:0] n);
    return (n == 16'd0) ? 16'd1 : n;
  endfunction

  // Value on the wire for frame bit k of command word w.
  function automatic logic frame_bit(input logic [31:0] w, input logic [5:0] k);
    logic [5:0] pos;
    if (k < 6'(PRE_BITS)) return 1'b1;
    pos = 6'd63 - k;
    if (w[29:28] != OP_RD && k == TA_K)          return 1'b1;
    if (w[29:28] != OP_RD && k == TA_K + 6'd1)   return 1'b0;
    return w[pos[4:0]];
  endfunction

  // Whether the master drives frame bit k.
  function automatic logic drives(input logic is_rd, input logic [5:0] k);
    return !(is_rd && k >= TA_K);
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick   = run && (cnt == half - 1'b1);
  assign rise_p = tick && !mdc;
  assign fall_p = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cmd_word,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [31:0] data_q,
  output logic        done_p
);
  logic [5:0] bit_idx;
  logic [5:0] next_idx;
  logic       is_rd;

  assign is_rd    = (data_q[29:28] == OP_RD);
  assign next_idx = bit_idx + 6'd1;
  assign done_p   = busy && fall_p && (bit_idx == LAST_K);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      data_q  <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_idx <= '0;
      data_q  <= cmd_word;
      mdio_o  <= frame_bit(cmd_word, 6'd0);
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_p && is_rd && bit_idx >= DATA_K)
        data_q[15:0] <= {data_q[14:0], mdio_i};
      if (fall_p) begin
        if (bit_idx == LAST_K) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end else begin
          bit_idx <= next_idx;
          mdio_o  <= frame_bit(data_q, next_idx);
          mdio_oe <= drives(is_rd, next_idx);
        end
      end
    end
  end

  // R3
  mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$past(fall_p) && !$past(start) |-> $stable(mdio_o));
  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_rd && bit_idx >= TA_K |-> !mdio_oe);
  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_rd |-> mdio_oe);
  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_idx) == LAST_K);
endmodule

// File: rtl/mdio_event.sv
module mdio_event #(
  parameter int EVT_BIT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_p,
  input  logic        clr_we,
  input  logic [31:0] clr_data,
  output logic        evt
);
  logic clr_hit;
  logic unused_clr_bits;

  assign clr_hit         = clr_we && clr_data[EVT_BIT];
  assign unused_clr_bits = ^clr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt <= 1'b0;
    else if (set_p)   evt <= 1'b1;
    else if (clr_hit) evt <= 1'b0;
  end

  // R7
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_p |=> evt);
  // R7
  evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt) |-> $past(set_p));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int EVT_BIT = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W:0]   speed_cfg,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  input  logic             evt_we,
  input  logic [31:0]      evt_wdata,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [31:0]      data_q,
  output logic             busy,
  output logic             evt_done
);
  logic [DIV_W-1:0] half_d, half_q;
  logic             start, rise_p, fall_p, done_p;
  logic             unused_spd_lsb;

  assign unused_spd_lsb = speed_cfg[0];
  assign half_d = DIV_W'(eff_half(16'(speed_cfg[DIV_W:1])));
  assign start  = cmd_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     half_q <= DIV_W'(1);
    else if (start) half_q <= half_d;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) clk_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p));

  mdio_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_wdata),
    .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .data_q(data_q), .done_p(done_p));

  mdio_event #(.EVT_BIT(EVT_BIT)) evt_i (
    .clk(clk), .rst_n(rst_n), .set_p(done_p),
    .clr_we(evt_we), .clr_data(evt_wdata), .evt(evt_done));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(data_q[31:16]));
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_p));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  speed_cfg = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        evt_we = 1'b0;
  logic [31:0] evt_wdata = '0;
  logic        mdio_i = 1'b0;
  logic        mdc, mdio_o, mdio_oe, busy, evt_done;
  logic [31:0] data_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .speed_cfg(speed_cfg),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .evt_we(evt_we), .evt_wdata(evt_wdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .data_q(data_q), .busy(busy), .evt_done(evt_done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_n(input logic [6:0] spd);
    return (spd[6:1] == 0) ? 1 : int'(spd[6:1]);
  endfunction

  function automatic bit is_read(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic logic exp_bit(input logic [31:0] w, input int k);
    logic [31:0] x = w;
    if (k < 32) return 1'b1;
    if (!is_read(w)) x[17:16] = 2'b10;
    return x[63-k];
  endfunction

  function automatic logic [31:0] exp_reg(input logic [31:0] w, input logic [15:0] rd);
    return is_read(w) ? {w[31:16], rd} : w;
  endfunction

  task automatic do_frame(input logic [6:0] spd, input logic [31:0] word,
                          input logic [15:0] rdv, input bit inject);
    int n = eff_n(spd);
    int k = 0, bcnt = 0, hi_len = 0;
    bit bad_hi = 0, bad_chg = 0, bad_bit = 0, bad_oe = 0;
    logic prev_mdc = 1'b0, prev_o;
    logic got_o [64];
    logic got_oe[64];
    @(negedge clk);
    speed_cfg = spd; cmd_wdata = word; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", busy, 1);
    prev_o = mdio_o;
    while (busy && bcnt < 20000) begin
      bcnt++;
      if (inject && bcnt == 40 * n) begin
        cmd_wdata = ~word; cmd_we = 1'b1;
      end else begin
        cmd_we = 1'b0;
      end
      if (mdio_o != prev_o && !(prev_mdc && !mdc)) bad_chg = 1;
      prev_o = mdio_o;
      if (mdc && !prev_mdc) begin
        if (k < 64) begin got_o[k] = mdio_o; got_oe[k] = mdio_oe; end
        k++;
        hi_len = 1;
      end else if (mdc) begin
        hi_len++;
      end
      if (!mdc && prev_mdc) begin
        if (hi_len != n) bad_hi = 1;
        mdio_i = (k >= 48 && k < 64) ? rdv[63-k] : 1'($urandom);
      end
      prev_mdc = mdc;
      @(negedge clk);
    end
    cmd_we = 1'b0;
    check(k == 64, "R2 rising edge count", k, 64);
    check(bcnt == 128 * n, "R6 busy length", bcnt, 128 * n);
    check(!bad_hi, "R1 mdc high phase", bad_hi, 0);
    check(!bad_chg, "R3 mdio change off falling edge", bad_chg, 0);
    for (int i = 0; i < 64 && i < k; i++) begin
      logic eoe = !(is_read(word) && i >= 46);
      if (got_oe[i] !== eoe) bad_oe = 1;
      if (eoe && got_o[i] !== exp_bit(word, i)) bad_bit = 1;
    end
    check(!bad_bit, "R2 R4 frame bits", bad_bit, 0);
    check(!bad_oe, is_read(word) ? "R5 read release" : "R4 write drive", bad_oe, 0);
    check(data_q == exp_reg(word, rdv),
          is_read(word) ? "R5 read data" : (inject ? "R8 ignored cmd" : "R10 write reg"),
          data_q, exp_reg(word, rdv));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", {mdc, mdio_oe}, 0);
    check(evt_done == 1'b1, "R7 event set", evt_done, 1);
  endtask

  task automatic evt_write(input logic [31:0] d);
    @(negedge clk);
    evt_we = 1'b1; evt_wdata = d;
    @(negedge clk);
    evt_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h1d5a));
    repeat (3) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0 && busy == 0 && evt_done == 0 && data_q == 0,
          "R9 reset state", {mdc, mdio_oe, busy, evt_done, data_q}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 write with wrong turnaround bits, speed field 3 (bit 0 ignored: N=1)
    do_frame(7'd3, 32'h5F8E_1234 & 32'hFFFC_FFFF | 32'h0001_0000, 16'h0, 0);
    evt_write(32'hFF7F_FFFF);
    check(evt_done == 1'b1, "R7 clear with bit23 low ignored", evt_done, 1);
    evt_write(32'h0080_0000);
    check(evt_done == 1'b0, "R7 clear", evt_done, 0);

    // R5 read, N=0 treated as 1
    do_frame(7'd0, 32'h6A5C_0000, 16'hBEEF, 0);
    evt_write(32'h0080_0000);
    // R1 largest divider
    do_frame(7'h7F, 32'h6123_4000, 16'h8001, 0);
    evt_write(32'h0080_0000);
    // R8 mid-frame command on a write and a read
    do_frame(7'd4, 32'h5432_ABCD, 16'h0, 1);
    evt_write(32'h0080_0000);
    do_frame(7'd6, 32'h6987_0000, 16'h1357, 1);
    evt_write(32'h0080_0000);

    for (int t = 0; t < 20; t++) begin
      w = $urandom;
      w[31:30] = 2'b01;
      w[29:28] = ($urandom % 2) ? 2'b10 : 2'b01;
      if ((t % 7) == 3) w[29:28] = 2'b11;
      do_frame(7'($urandom % 14), w, 16'($urandom), (t % 5) == 2);
      evt_write(32'h0080_0000);
      check(evt_done == 1'b0, "R7 clear after frame", evt_done, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule